// File: doc/BRIEF.md
# Two-Bit Bidirectional Boundary-Scan Chain

This block is the boundary-scan data register for a bank of bidirectional pads. It sits between the core's pad drivers and the pads. Each pad contributes two scan cells to one serial chain. One is an output-enable cell and the other is a data cell. The chain is clocked by the test clock and steered by the capture, shift and update strobes of an external TAP controller. A mode input selects SAMPLE/PRELOAD (mode low) or EXTEST (mode high).

On capture, every data cell loads the value sensed at its pad. In the same cycle every enable cell loads the enable that is currently applied to that pad. The chain then shifts out toward the test host. A new pattern shifts in at the same time, and an update edge copies the whole chain into a separate update bank. In SAMPLE/PRELOAD the pads follow the core, so normal operation is not disturbed. In EXTEST the update bank drives the pads. A pad whose enable bit is 1 drives its data bit. A pad whose enable bit is 0 is left at high impedance, and its data cell captures whatever another device drives onto the net.

Top module: `bscan_pad_chain`

## Requirements
- R1: While rst_ni is low, the chain, the update bank and tdo_o are all 0. With extest_i high, every pad_oe_o bit is therefore 0.
- R2: While extest_i is 0, pad_out_o equals core_out_i and pad_oe_o equals core_oe_i, whatever the update bank holds.
- R3: On a rising tck_i edge with capture_dr_i high, the data cell of every pad loads pad_in_i. In the same edge, the enable cell of every pad loads that pad's current pad_oe_o.
- R4: On a rising edge with shift_dr_i high and capture_dr_i low, the chain shifts one place. The order is tdi_i → pad 0 enable → pad 0 data → pad 1 enable → … → pad N-1 data → tdo_o. tdo_o is registered on the falling edge of tck_i. Counting from the shift index k=0, the k-th bit out after a capture is therefore the data bit of pad N-1-k/2 when k is even, and its enable bit when k is odd.
- R5: The update bank changes only on a rising edge with update_dr_i high, and it then loads all 2N cells together. During shift and capture the EXTEST pad outputs stay unchanged.
- R6: While extest_i is 1, pad_oe_o[i] equals the pad's updated enable bit, where 1 means drive and 0 means high impedance. A driving pad outputs its updated data bit on pad_out_o[i].
- R7: In EXTEST, capture loads a high-impedance pad's data cell with the externally driven value seen on pad_in_i[i].
- R8: With neither capture_dr_i nor shift_dr_i high, the chain holds its contents. When capture_dr_i and shift_dr_i are both high, the capture takes effect and the shift does not.
- R9: A pattern preloaded in SAMPLE/PRELOAD appears on the pads as soon as extest_i rises, with no further update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tdi_i | input | 1 | Serial scan input |
| capture_dr_i | input | 1 | Capture strobe from the TAP controller |
| shift_dr_i | input | 1 | Shift strobe from the TAP controller |
| update_dr_i | input | 1 | Update strobe from the TAP controller |
| extest_i | input | 1 | 1 = EXTEST, 0 = SAMPLE/PRELOAD |
| core_out_i | input | N_PADS | Core output data, one bit per pad |
| core_oe_i | input | N_PADS | Core output enable, 1 = drive |
| pad_in_i | input | N_PADS | Value sensed at each pad |
| pad_out_o | output | N_PADS | Data toward the pad drivers |
| pad_oe_o | output | N_PADS | Enable toward the pad drivers, 1 = drive |
| tdo_o | output | 1 | Serial scan output, changes on the falling edge |

## Verification
Pad outputs are combinational from the mode input and the update bank. They are checked 2 ns after the rising edge that updates them, or 1 ns after extest_i changes. A captured bit first reaches tdo_o at the falling edge after the capture edge. Each later bit follows one falling edge after its shift edge. The bench therefore reads each outgoing bit 2 ns after the next rising edge, before the next falling edge, and once also just after a falling edge to confirm the advance happens there. Every input is changed 2 ns after a rising edge, well clear of either clock edge.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef struct packed {
    logic oe;
    logic dat;
  } pad_bits_t;
endpackage

// File: rtl/bscan_pad_cell.sv
module bscan_pad_cell
  import bscan_pkg::*;
(
  input  logic      tck_i,
  input  logic      rst_ni,
  input  logic      capture_i,
  input  logic      shift_i,
  input  logic      update_i,
  input  logic      scan_i,
  input  logic      sense_i,
  input  logic      oe_sense_i,
  output logic      scan_o,
  output pad_bits_t upd_o
);
  logic en_q, dat_q;

  // capture has priority over shift
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dat_q <= 1'b0;
    end else if (capture_i) begin
      en_q  <= oe_sense_i;
      dat_q <= sense_i;
    end else if (shift_i) begin
      en_q  <= scan_i;
      dat_q <= en_q;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) upd_o <= '0;
    else if (update_i) upd_o <= '{oe: en_q, dat: dat_q};
  end

  assign scan_o = dat_q;

  AST_CAPTURE_CELLS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> (dat_q == $past(sense_i)) && (en_q == $past(oe_sense_i))); // R3
  AST_SHIFT_STEP: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (en_q == $past(scan_i)) && (dat_q == $past(en_q))); // R4
  AST_CHAIN_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!shift_i && !capture_i) |=> $stable({en_q, dat_q})); // R8
  AST_UPDATE_ONLY: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_o)); // R5
endmodule

// File: rtl/bscan_tdo_stage.sv
module bscan_tdo_stage (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic last_i,
  output logic tdo_o
);
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_o <= 1'b0;
    else         tdo_o <= last_i;
  end
endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
  import bscan_pkg::*;
#(
  parameter int N_PADS = 8
) (
  input  logic                  extest_i,
  input  logic [N_PADS-1:0]     core_out_i,
  input  logic [N_PADS-1:0]     core_oe_i,
  input  pad_bits_t             upd_i [N_PADS],
  output logic [N_PADS-1:0]     pad_out_o,
  output logic [N_PADS-1:0]     pad_oe_o
);
  for (genvar i = 0; i < N_PADS; i++) begin : g_pad
    always_comb begin
      if (extest_i) begin
        pad_out_o[i] = upd_i[i].dat;
        pad_oe_o[i]  = upd_i[i].oe;
      end else begin
        pad_out_o[i] = core_out_i[i];
        pad_oe_o[i]  = core_oe_i[i];
      end
    end
  end
endmodule

// File: rtl/bscan_pad_chain.sv
module bscan_pad_chain
  import bscan_pkg::*;
#(
  parameter int N_PADS = 8
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              extest_i,
  input  logic [N_PADS-1:0] core_out_i,
  input  logic [N_PADS-1:0] core_oe_i,
  input  logic [N_PADS-1:0] pad_in_i,
  output logic [N_PADS-1:0] pad_out_o,
  output logic [N_PADS-1:0] pad_oe_o,
  output logic              tdo_o
);
  localparam int LAST = N_PADS - 1;

  logic [N_PADS:0] link;
  pad_bits_t       upd [N_PADS];

  assign link[0] = tdi_i;

  for (genvar i = 0; i < N_PADS; i++) begin : g_cell
    bscan_pad_cell u_cell (
      .tck_i      (tck_i),
      .rst_ni     (rst_ni),
      .capture_i  (capture_dr_i),
      .shift_i    (shift_dr_i),
      .update_i   (update_dr_i),
      .scan_i     (link[i]),
      .sense_i    (pad_in_i[i]),
      .oe_sense_i (pad_oe_o[i]),
      .scan_o     (link[i+1]),
      .upd_o      (upd[i])
    );
  end

  bscan_pad_mux #(.N_PADS(N_PADS)) u_mux (
    .extest_i   (extest_i),
    .core_out_i (core_out_i),
    .core_oe_i  (core_oe_i),
    .upd_i      (upd),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o)
  );

  bscan_tdo_stage u_tdo (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .last_i (link[N_PADS]),
    .tdo_o  (tdo_o)
  );

  AST_TDO_ALIGN: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_o == link[N_PADS]); // R4
  AST_EXTEST_STABLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (extest_i && $past(extest_i) && !$past(update_dr_i))
      |-> $stable(pad_oe_o) && $stable(pad_out_o[LAST])); // R5
endmodule

// File: tb/bscan_pad_chain_bench.sv
module bscan_pad_chain_bench;
  localparam int N = 8;
  localparam int L = 2 * N;

  logic tck = 1'b0;
  always #10 tck = ~tck;

  logic rst_n, tdi, capture, shift, update, extest;
  logic [N-1:0] core_out, core_oe, ext_drv, pad_in, pad_out, pad_oe;
  logic tdo;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_drv);

  bscan_pad_chain #(.N_PADS(N)) u_bscan_pad_chain (
    .tck_i(tck), .rst_ni(rst_n), .tdi_i(tdi), .capture_dr_i(capture),
    .shift_dr_i(shift), .update_dr_i(update), .extest_i(extest),
    .core_out_i(core_out), .core_oe_i(core_oe), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .tdo_o(tdo));

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge tck);
    #2;
  endtask

  function automatic logic seq_bit(input int k, input logic [N-1:0] d, input logic [N-1:0] e);
    int p;
    p = N - 1 - k / 2;
    return (k % 2 == 0) ? d[p] : e[p];
  endfunction

  // capture, optional idle, shift out/in L bits, update
  task automatic run_scan(input logic [N-1:0] exp_d, input logic [N-1:0] exp_e,
                          input logic [N-1:0] new_d, input logic [N-1:0] new_e,
                          input int idle, input bit cap_and_shift, input string tag);
    logic [N-1:0] hold_oe, hold_out;
    hold_oe  = pad_oe;
    hold_out = pad_out;
    capture = 1'b1;
    shift   = cap_and_shift;
    cyc();
    capture = 1'b0;
    shift   = 1'b0;
    for (int j = 0; j < idle; j++) begin
      tdi = 1'($urandom);
      cyc();
    end
    shift = 1'b1;
    for (int k = 0; k < L; k++) begin
      tdi = seq_bit(k, new_d, new_e);
      cyc();
      chk({tag, " R4 tdo bit"}, 32'(tdo), 32'(seq_bit(k, exp_d, exp_e)));
      if (k == 0) begin
        #10;
        chk("R4 tdo advances on falling edge", 32'(tdo), 32'(seq_bit(1, exp_d, exp_e)));
      end
      if (extest) begin
        chk("R5 pads stable while shifting", 32'(pad_oe), 32'(hold_oe));
        chk("R5 pad data stable while shifting", 32'(pad_out & hold_oe), 32'(hold_out & hold_oe));
      end
    end
    shift  = 1'b0;
    update = 1'b1;
    cyc();
    update = 1'b0;
  endtask

  initial begin
    #4_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] pd, pe, qd, qe, sd;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; tdi = 1'b0; capture = 1'b0; shift = 1'b0; update = 1'b0;
    extest = 1'b1; core_out = '1; core_oe = '1; ext_drv = '0;
    cyc(); cyc();
    chk("R1 pads hi-z in reset", 32'(pad_oe), 32'h0);
    chk("R1 tdo in reset", 32'(tdo), 32'h0);
    rst_n = 1'b1;
    cyc();
    chk("R1 pads hi-z after reset", 32'(pad_oe), 32'h0);
    extest = 1'b0;
    #1;
    chk("R2 core pass-through", 32'(pad_oe), 32'(core_oe));

    // directed: hold through idle, then capture and shift together
    core_out = 8'hA5; core_oe = 8'h3C; ext_drv = 8'h0F;
    #1;
    sd = (core_oe & core_out) | (~core_oe & ext_drv);
    run_scan(sd, core_oe, 8'h00, 8'hFF, 3, 1'b0, "R8 hold");
    run_scan(sd, core_oe, 8'h55, 8'hF0, 0, 1'b1, "R8 capture priority R3");
    chk("R2 sample leaves pads to core", 32'(pad_out), 32'(core_out));
    extest = 1'b1;
    #1;
    chk("R9 preload enable", 32'(pad_oe), 32'hF0);
    chk("R9 preload data", 32'(pad_out & 8'hF0), 32'(8'h55 & 8'hF0));
    extest = 1'b0;
    #1;

    for (int it = 0; it < 20; it++) begin
      core_out = N'($urandom); core_oe = N'($urandom); ext_drv = N'($urandom);
      pd = N'($urandom); pe = N'($urandom);
      qd = N'($urandom); qe = N'($urandom);
      if (it == 0) begin pe = '0; qe = '1; end
      #1;
      sd = (core_oe & core_out) | (~core_oe & ext_drv);
      run_scan(sd, core_oe, pd, pe, 0, 1'b0, "R3 sample");
      chk("R2 pads follow core out", 32'(pad_out), 32'(core_out));
      chk("R2 pads follow core oe", 32'(pad_oe), 32'(core_oe));
      extest = 1'b1;
      #1;
      chk("R9 R6 extest enable", 32'(pad_oe), 32'(pe));
      chk("R6 extest drive data", 32'(pad_out & pe), 32'(pd & pe));
      ext_drv = N'($urandom);
      #1;
      run_scan((pe & pd) | (~pe & ext_drv), pe, qd, qe, it % 3, 1'b0, "R7 extest");
      chk("R5 R6 updated enable", 32'(pad_oe), 32'(qe));
      chk("R6 updated data", 32'(pad_out & qe), 32'(qd & qe));
      extest = 1'b0;
      #1;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule